// File: doc/BRIEF.md
# Two-Stage Key Debounce Filter

This block qualifies raw key samples from a matrix scanner before any key event is reported. The scanner presents down samples for individual key indices during a scan cycle and then pulses an end-of-cycle strobe. A key counts as down in a cycle if at least one accepted down sample names it. Otherwise it counts as up.

Each tracked key lives in one slot of a small debounce buffer and passes through two stages. The first is a short micro filter. It confirms a press over a few cycles. After the press is reported, the same counter runs the other way to confirm the release, stepping once per run of up cycles, where the run length is set by the cycle-extend factor. The second is a macro filter. It needs a programmable number of consecutive down cycles, or of consecutive up cycles, before it emits an event.

After each strobe the block evaluates its slots one per clock and emits at most one event per clock. It can then hold off the scanner for an idle gap, counted in units of 4 clocks.

Top module: `kd_filter`

## Requirements
- R1: A new key must be seen down in `cfg_micro`+1 consecutive scan cycles to pass the micro stage. An up cycle before that frees its slot and emits no event.
- R2: After a down event, the release counter is loaded with `cfg_micro`+1. It drops by one after each run of F consecutive up cycles. F is `cfg_ext_cnt` when extension is enabled and the count is nonzero, otherwise F is 1. A down cycle reloads the counter and clears the run. When the counter reaches zero, the key enters the macro up stage.
- R3: After the micro stage passes, `cfg_mdn` consecutive down cycles (0 acts as 1) emit an event with `ev_up`=0 and `ev_key` set to the key index.
- R4: An up cycle during the macro down stage resets its count to zero without freeing the slot. With a threshold of 3, the pattern D,D,U,D,D,D emits on the last cycle.
- R5: In the macro up stage, `cfg_mup` consecutive up cycles (0 acts as 1) emit an event with `ev_up`=1 and free the slot. A down cycle resets that count.
- R6: A strobe accepted while `scan_rdy`=1 drops `scan_rdy` for NSLOT clocks. When synchronized `cfg_ext_en` is set, a further 4×`cfg_ext_cnt` clocks are added.
- R7: Samples and strobes presented while `scan_rdy`=0 are ignored.
- R8: At most NSLOT keys are tracked. A new key is placed in the lowest free slot. A new key that arrives while all slots are busy is ignored until a slot is freed.
- R9: The event of slot i appears on the outputs for one clock, i+1 clocks after the edge that accepted the strobe. Events therefore come out in slot order, one per clock.
- R10: After reset, `scan_rdy`=1, `ev_vld`=0 and every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_micro | input | 2 | Micro setting; a press needs setting+1 down cycles |
| cfg_mdn | input | 4 | Macro down threshold in scan cycles |
| cfg_mup | input | 4 | Macro up threshold in scan cycles |
| cfg_ext_cnt | input | 7 | Gap length in units of 4 clocks and release step factor |
| cfg_ext_en | input | 1 | Extension enable, asynchronous, synchronized inside |
| smp_vld | input | 1 | Sample strobe |
| smp_key | input | KEY_W | Sampled key index |
| smp_down | input | 1 | Sampled state, 1 = down |
| cyc_end | input | 1 | End-of-scan-cycle strobe |
| scan_rdy | output | 1 | Block accepts samples and strobes |
| ev_vld | output | 1 | Qualified event valid |
| ev_up | output | 1 | 1 = release event, 0 = press event |
| ev_key | output | KEY_W | Key index of the event |

## Verification
The bench uses the defaults NSLOT=4 and KEY_W=8. Five distinct keys in one scan therefore overrun the buffer, and the dropped fifth key and the per-slot event timing become visible at the ports. The extension count is set to 2. This makes both the 8-clock gap and the two-cycle release step short enough to count exactly. Micro settings 0, 1 and 3 cover the smallest, a middle and the default press filter.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [2:0] {
    PH_FREE, PH_MDN, PH_QDN, PH_HELD, PH_QUP
  } kd_phase_e;

  typedef struct packed {
    logic [2:0] uth;   // micro threshold, 1..4
    logic [4:0] dth;   // macro down threshold, >= 1
    logic [4:0] uph;   // macro up threshold, >= 1
    logic [7:0] fac;   // release step factor, >= 1
  } kd_cfg_t;
endpackage

// File: rtl/kd_sync.sv
module kd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end
  assign q = sr[STAGES-1];
endmodule

// File: rtl/kd_seq.sv
module kd_seq #(
  parameter int NSLOT = 4,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_end,
  input  logic             ext_en,
  input  logic [CNT_W-1:0] ext_cnt,
  output logic             rdy,
  output logic [NSLOT-1:0] eval
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int GAP_W = CNT_W + 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSLOT - 1);

  typedef enum logic [1:0] {S_RDY, S_EVAL, S_GAP} seq_e;
  seq_e             st;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_RDY;
      idx  <= '0;
      gcnt <= '0;
    end else begin
      case (st)
        S_RDY: if (cyc_end) begin
          st  <= S_EVAL;
          idx <= '0;
        end
        S_EVAL: begin
          if (idx == LAST) begin
            // gap length fixed here; later enable changes do not cut it
            if (ext_en && ext_cnt != '0) begin
              st   <= S_GAP;
              gcnt <= {ext_cnt, 2'b00} - GAP_W'(1);
            end else begin
              st <= S_RDY;
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_GAP: begin
          if (gcnt == '0) st <= S_RDY;
          else            gcnt <= gcnt - GAP_W'(1);
        end
        default: st <= S_RDY;
      endcase
    end
  end

  assign rdy = (st == S_RDY);

  for (genvar i = 0; i < NSLOT; i++) begin : g_ev
    assign eval[i] = (st == S_EVAL) && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/kd_slot.sv
module kd_slot
  import kd_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  kd_cfg_t          cfg,
  input  logic             alloc,
  input  logic             hit_set,
  input  logic [KEY_W-1:0] new_key,
  input  logic             eval,
  output logic             busy,
  output logic [KEY_W-1:0] key,
  output logic             emit,
  output logic             emit_up
);
  kd_phase_e  ph, ph_n;
  logic       hit;
  logic [2:0] ucnt, ucnt_n;
  logic [3:0] mcnt, mcnt_n;
  logic [6:0] erun, erun_n;

  always_comb begin
    ph_n    = ph;
    ucnt_n  = ucnt;
    mcnt_n  = mcnt;
    erun_n  = erun;
    emit    = 1'b0;
    emit_up = 1'b0;
    if (eval) begin
      case (ph)
        PH_MDN: begin
          if (!hit) ph_n = PH_FREE;
          else if (ucnt + 3'd1 >= cfg.uth) begin
            ph_n   = PH_QDN;
            mcnt_n = '0;
          end else ucnt_n = ucnt + 3'd1;
        end
        PH_QDN: begin
          if (!hit) mcnt_n = '0;
          else if ({1'b0, mcnt} + 5'd1 >= cfg.dth) begin
            emit   = 1'b1;
            ph_n   = PH_HELD;
            ucnt_n = cfg.uth;
            erun_n = '0;
          end else mcnt_n = mcnt + 4'd1;
        end
        PH_HELD: begin
          if (hit) begin
            ucnt_n = cfg.uth;
            erun_n = '0;
          end else if ({1'b0, erun} + 8'd1 >= cfg.fac) begin
            erun_n = '0;
            if (ucnt <= 3'd1) begin
              ph_n   = PH_QUP;
              ucnt_n = '0;
              mcnt_n = '0;
            end else ucnt_n = ucnt - 3'd1;
          end else erun_n = erun + 7'd1;
        end
        PH_QUP: begin
          if (hit) mcnt_n = '0;
          else if ({1'b0, mcnt} + 5'd1 >= cfg.uph) begin
            emit    = 1'b1;
            emit_up = 1'b1;
            ph_n    = PH_FREE;
          end else mcnt_n = mcnt + 4'd1;
        end
        default: ph_n = PH_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_FREE;
      hit  <= 1'b0;
      key  <= '0;
      ucnt <= '0;
      mcnt <= '0;
      erun <= '0;
    end else if (alloc) begin
      ph   <= PH_MDN;
      hit  <= 1'b1;
      key  <= new_key;
      ucnt <= '0;
      mcnt <= '0;
      erun <= '0;
    end else begin
      ph   <= ph_n;
      ucnt <= ucnt_n;
      mcnt <= mcnt_n;
      erun <= erun_n;
      if (eval)         hit <= 1'b0;
      else if (hit_set) hit <= 1'b1;
    end
  end

  assign busy = (ph != PH_FREE);
endmodule

// File: rtl/kd_filter.sv
module kd_filter
  import kd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_micro,
  input  logic [3:0]       cfg_mdn,
  input  logic [3:0]       cfg_mup,
  input  logic [6:0]       cfg_ext_cnt,
  input  logic             cfg_ext_en,
  input  logic             smp_vld,
  input  logic [KEY_W-1:0] smp_key,
  input  logic             smp_down,
  input  logic             cyc_end,
  output logic             scan_rdy,
  output logic             ev_vld,
  output logic             ev_up,
  output logic [KEY_W-1:0] ev_key
);
  logic             ext_en_s;
  logic [NSLOT-1:0] eval, slot_busy, match, alloc, hit_set, emit, emit_up;
  logic [KEY_W-1:0] slot_key [NSLOT];
  kd_cfg_t          cfg;
  logic             acc, ev_d, up_d;
  logic [KEY_W-1:0] key_d;

  kd_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(cfg_ext_en), .q(ext_en_s)
  );

  kd_seq #(.NSLOT(NSLOT), .CNT_W(7)) u_seq (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .ext_en(ext_en_s),
    .ext_cnt(cfg_ext_cnt), .rdy(scan_rdy), .eval(eval)
  );

  always_comb begin
    cfg.uth = {1'b0, cfg_micro} + 3'd1;
    cfg.dth = (cfg_mdn == '0) ? 5'd1 : {1'b0, cfg_mdn};
    cfg.uph = (cfg_mup == '0) ? 5'd1 : {1'b0, cfg_mup};
    cfg.fac = (ext_en_s && cfg_ext_cnt != '0) ? {1'b0, cfg_ext_cnt} : 8'd1;
  end

  assign acc = scan_rdy && smp_vld && smp_down;

  always_comb begin
    logic found;
    found = 1'b0;
    alloc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      match[i]   = slot_busy[i] && (slot_key[i] == smp_key);
      hit_set[i] = acc && match[i];
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (acc && !(|match) && !slot_busy[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    kd_slot #(.KEY_W(KEY_W)) u_slot (
      .clk(clk), .rst(rst), .cfg(cfg), .alloc(alloc[i]),
      .hit_set(hit_set[i]), .new_key(smp_key), .eval(eval[i]),
      .busy(slot_busy[i]), .key(slot_key[i]), .emit(emit[i]),
      .emit_up(emit_up[i])
    );
  end

  always_comb begin
    ev_d  = 1'b0;
    up_d  = 1'b0;
    key_d = '0;
    for (int i = 0; i < NSLOT; i++) begin
      ev_d  = ev_d | emit[i];
      up_d  = up_d | (emit[i] & emit_up[i]);
      key_d = key_d | ({KEY_W{emit[i]}} & slot_key[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_vld <= 1'b0;
      ev_up  <= 1'b0;
      ev_key <= '0;
    end else begin
      ev_vld <= ev_d;
      ev_up  <= up_d;
      ev_key <= key_d;
    end
  end
endmodule

// File: rtl/kd_filter_chk.sv
module kd_filter_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_end,
  input logic             scan_rdy,
  input logic             ev_vld,
  input logic [NSLOT-1:0] slot_busy
);
  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (scan_rdy && !ev_vld && slot_busy == '0)); // R10

  AST_CYC_TAKEN: assert property (@(posedge clk) disable iff (rst)
    scan_rdy && cyc_end |=> !scan_rdy); // R6

  if (NSLOT > 1) begin : g_span
    AST_EVAL_SPAN: assert property (@(posedge clk) disable iff (rst)
      $fell(scan_rdy) |=> !scan_rdy); // R6
  end

  AST_EV_AFTER_EVAL: assert property (@(posedge clk) disable iff (rst)
    ev_vld |-> $past(!scan_rdy)); // R9

  AST_NO_ALLOC_BUSY: assert property (@(posedge clk) disable iff (rst)
    !scan_rdy |=> $countones(slot_busy) <= $past($countones(slot_busy))); // R7
endmodule

bind kd_filter kd_filter_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .cyc_end(cyc_end), .scan_rdy(scan_rdy),
  .ev_vld(ev_vld), .slot_busy(slot_busy)
);

// File: tb/kd_filter_tb_top.sv
module kd_filter_tb_top;
  localparam int NSLOT = 4;
  localparam int KEY_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_micro = 2'd3;
  logic [3:0] cfg_mdn = 4'd3, cfg_mup = 4'd3;
  logic [6:0] cfg_ext_cnt = 7'd0;
  logic cfg_ext_en = 1'b0;
  logic smp_vld = 1'b0, smp_down = 1'b0, cyc_end = 1'b0;
  logic [KEY_W-1:0] smp_key = '0;
  logic scan_rdy, ev_vld, ev_up;
  logic [KEY_W-1:0] ev_key;

  always #4 clk = ~clk;

  kd_filter #(.NSLOT(NSLOT), .KEY_W(KEY_W)) dut_i (.*);

  int n_vec = 0, n_bad = 0;
  int tcnt = 0, t_ce = 0, busy_len = 0;
  int n_ev = 0;
  logic [KEY_W-1:0] lg_key [16];
  logic             lg_up  [16];
  int               lg_off [16];

  always @(posedge clk) tcnt <= tcnt + 1;

  always @(negedge clk) if (ev_vld && n_ev < 16) begin
    lg_key[n_ev] = ev_key;
    lg_up[n_ev]  = ev_up;
    lg_off[n_ev] = tcnt - t_ce;
    n_ev++;
  end

  task automatic chk(input int act, input int exp, input string req);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one scan cycle: down samples for up to 5 keys, then strobe
  task automatic scan(input int n, input int k0, input int k1, input int k2,
                      input int k3, input int k4, input int inj = -1);
    int ks [5];
    ks = '{k0, k1, k2, k3, k4};
    @(negedge clk);
    n_ev = 0;
    for (int i = 0; i < n; i++) begin
      smp_vld = 1'b1; smp_down = 1'b1; smp_key = KEY_W'(ks[i]);
      @(negedge clk);
    end
    smp_vld = 1'b0; smp_down = 1'b0;
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    t_ce = tcnt;
    busy_len = 0;
    if (inj >= 0) begin
      smp_vld = 1'b1; smp_down = 1'b1; smp_key = KEY_W'(inj); cyc_end = 1'b1;
    end
    while (!scan_rdy) begin
      busy_len++;
      @(negedge clk);
      smp_vld = 1'b0; smp_down = 1'b0; cyc_end = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic empty_scans(input int n, inout int tot);
    for (int i = 0; i < n; i++) begin
      scan(0, 0, 0, 0, 0, 0);
      tot += n_ev;
    end
  endtask

  task automatic t_reset();
    chk(scan_rdy, 1, "R10 scan_rdy after reset");
    chk(ev_vld, 0, "R10 ev_vld after reset");
  endtask

  task automatic t_default();
    int tot = 0;
    cfg_micro = 2'd3; cfg_mdn = 4'd3; cfg_mup = 4'd3;
    for (int i = 0; i < 6; i++) begin
      scan(1, 5, 0, 0, 0, 0);
      tot += n_ev;
    end
    chk(tot, 0, "R1 R3 no event before 7 down cycles");
    chk(busy_len, NSLOT, "R6 eval span without gap");
    scan(1, 5, 0, 0, 0, 0);
    chk(n_ev, 1, "R3 down event count");
    chk(lg_key[0], 5, "R3 down event key");
    chk(lg_up[0], 0, "R3 down event ev_up");
    tot = 0;
    empty_scans(6, tot);
    chk(tot, 0, "R2 no release before 4+3 up cycles");
    scan(0, 0, 0, 0, 0, 0);
    chk(n_ev, 1, "R5 up event count");
    chk(lg_up[0], 1, "R5 up event ev_up");
    chk(lg_key[0], 5, "R5 up event key");
  endtask

  task automatic t_noise();
    int tot = 0;
    cfg_micro = 2'd3; cfg_mdn = 4'd1; cfg_mup = 4'd1;
    for (int i = 0; i < 3; i++) begin
      scan(1, 6, 0, 0, 0, 0);
      tot += n_ev;
    end
    empty_scans(4, tot);
    chk(tot, 0, "R1 short press filtered");
  endtask

  task automatic t_macro();
    int tot = 0;
    cfg_micro = 2'd0; cfg_mdn = 4'd3; cfg_mup = 4'd1;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) scan(0, 0, 0, 0, 0, 0);
      else        scan(1, 7, 0, 0, 0, 0);
      tot += n_ev;
    end
    chk(tot, 0, "R4 miss resets macro count");
    scan(1, 7, 0, 0, 0, 0);
    chk(n_ev, 1, "R4 event after D,D,U,D,D,D");
    tot = 0;
    empty_scans(2, tot);
    chk(tot, 1, "R5 release with threshold 1");
  endtask

  task automatic t_extend();
    int tot = 0;
    cfg_micro = 2'd1; cfg_mdn = 4'd1; cfg_mup = 4'd1;
    cfg_ext_cnt = 7'd2; cfg_ext_en = 1'b1;
    repeat (4) @(negedge clk);
    scan(1, 20, 0, 0, 0, 0);
    chk(busy_len, NSLOT + 8, "R6 eval span with 4x2 gap");
    scan(1, 20, 0, 0, 0, 0);
    tot = n_ev;
    scan(1, 20, 0, 0, 0, 0);
    chk(tot, 0, "R1 micro 2 cycles before macro");
    chk(n_ev, 1, "R3 press with extension on");
    tot = 0;
    empty_scans(4, tot);
    chk(tot, 0, "R2 release steps scaled by factor 2");
    scan(0, 0, 0, 0, 0, 0);
    chk(n_ev, 1, "R2 release reached on fifth up cycle");
    chk(lg_up[0], 1, "R5 release flag with extension");
    cfg_ext_en = 1'b0;
    repeat (4) @(negedge clk);
    scan(0, 0, 0, 0, 0, 0);
    chk(busy_len, NSLOT, "R6 gap removed after disable");
  endtask

  task automatic t_ignore();
    int tot = 0;
    cfg_micro = 2'd1; cfg_mdn = 4'd1; cfg_mup = 4'd1;
    scan(1, 9, 0, 0, 0, 0, 9);
    chk(busy_len, NSLOT, "R7 strobe while busy ignored");
    scan(0, 0, 0, 0, 0, 0);
    scan(1, 9, 0, 0, 0, 0);
    chk(n_ev, 0, "R7 sample while busy ignored");
    empty_scans(2, tot);
  endtask

  task automatic t_full();
    int tot = 0;
    cfg_micro = 2'd0; cfg_mdn = 4'd1; cfg_mup = 4'd1;
    scan(5, 1, 2, 3, 4, 5);
    chk(n_ev, 0, "R1 micro pass only");
    scan(5, 1, 2, 3, 4, 5);
    chk(n_ev, NSLOT, "R8 only NSLOT keys tracked");
    for (int i = 0; i < 4; i++) begin
      chk(lg_key[i], i + 1, "R8 slot order key");
      chk(lg_off[i], i + 1, "R9 event offset after strobe");
    end
    empty_scans(2, tot);
    chk(tot, NSLOT, "R5 all released");
    scan(1, 5, 0, 0, 0, 0);
    scan(1, 5, 0, 0, 0, 0);
    chk(n_ev, 1, "R8 freed slot takes new key");
    chk(lg_key[0], 5, "R8 new key index");
    tot = 0;
    empty_scans(2, tot);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default();
    t_noise();
    t_macro();
    t_extend();
    t_ignore();
    t_full();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule